// File: doc/BRIEF.md
# Multi-Song Note Sequencer

This block plays back one of four built-in melodies, one score entry per quarter beat. A slow tempo strobe arrives at 8 Hz. The block divides it by two, so the score address moves forward once per quarter beat (4 Hz, 0.25 s). Each score entry holds a 5-bit note index. A note that lasts several quarter beats is stored in that many consecutive entries. The address counts modulo 183 and returns to 0 after the last entry, so the melody repeats without any outside help.

A 2-bit Gray-coded switch picks the song, so moving to the next song changes only one switch. The selected song's current note index is decoded into three outputs. The first is a 12-bit preset for a downstream tone divider. The second is a scale-degree digit for a display. The third is a one-hot octave indicator for three lamps. Tone synthesis and the display driver sit outside this block.

Top module: `melody_sequencer`

## Requirements
- R1: The address advances by one on every second cycle in which `tick_8hz` is high. The first advance comes on the second tick after reset or after a song change. Cycles without a tick never move the address.
- R2: In song s, entry a with a below the song's length L(s) holds note ((a>>1)*K(s)+B(s)) mod 21 + 1. Entries at or above L(s) hold a rest. The values are L = 183/150/96/40, K = 1/3/5/2 and B = 0/7/14/3 for songs 0/1/2/3.
- R3: The address runs from 0 to 182. An advance from 182 returns it to 0.
- R4: `song_sel` is Gray-coded. Switch 00 selects song 0, 01 selects song 1, 11 selects song 2 and 10 selects song 3.
- R5: When the decoded selection differs from the song in use, the next edge clears the address and the tick phase and starts the new song. This takes priority over a tick in the same cycle.
- R6: `degree_code` is ((n-1) mod 7)+1 for a note n in 1..21, and 0 for a rest.
- R7: `octave_led` is 001 for notes 1–7, 010 for notes 8–14, 100 for notes 15–21 and 000 for a rest.
- R8: `tone_preset` is 4095 for a rest. For notes 1..21 it is, in order: 1823, 2063, 2291, 2390, 2576, 2745, 2891, 2960, 3082, 3193, 3244, 3337, 3420, 3494, 3528, 3589, 3645, 3670, 3717, 3758, 3795.
- R9: While `rst_n` is low at a clock edge, the address and tick phase clear and the song is taken from the switches. The outputs then show entry 0 of that song.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_8hz | input | 1 | One-cycle tempo strobe at 8 Hz |
| song_sel | input | 2 | Gray-coded song switches |
| tone_preset | output | 12 | Divider preset for the current note |
| degree_code | output | 4 | Scale degree 1..7, or 0 for a rest |
| octave_led | output | 3 | One-hot octave indicator, or 000 for a rest |

## Verification
Several properties are checked on every cycle:
- the address stays in range and wraps from 182 to 0;
- it steps by one on an advance and holds otherwise;
- a song change clears it;
- a tick that does not advance is followed, at the next tick, by one that does;
- the three outputs agree on what a rest is, and the octave indicator is never more than one-hot.

The song contents, the exact preset values and the Gray-to-song mapping can only be shown by the bench. It compares every output on every cycle against its own model under random ticks, random switch changes and directed runs through the wrap and the rest padding.

// File: rtl/mseq_pkg.sv
// Package: shared constants and the computed song and preset tables.
// Assumes note indices are 5 bits; index 0 and anything above 21 is a rest.
package mseq_pkg;

    localparam int NOTE_W   = 5;
    localparam int PRESET_W = 12;
    localparam int DEG_W    = 4;
    localparam int OCT_W    = 3;
    localparam int NOTES    = 21;
    localparam logic [PRESET_W-1:0] REST_PRESET = 12'd4095;

    // Length of each stored song in score entries.
    function automatic int song_len(input int s);
        case (s)
            0:       return 183;
            1:       return 150;
            2:       return 96;
            default: return 40;
        endcase
    endfunction

    // Interval multiplier of each song's note pattern.
    function automatic int song_step(input int s);
        case (s)
            0:       return 1;
            1:       return 3;
            2:       return 5;
            default: return 2;
        endcase
    endfunction

    // Starting offset of each song's note pattern.
    function automatic int song_base(input int s);
        case (s)
            0:       return 0;
            1:       return 7;
            2:       return 14;
            default: return 3;
        endcase
    endfunction

    // Note index stored at entry a of song s. Entries past the end are rests.
    function automatic logic [NOTE_W-1:0] song_note(input int s, input int a);
        int v;
        if (a >= song_len(s)) return '0;
        v = (((a >> 1) * song_step(s)) + song_base(s)) % NOTES + 1;
        return NOTE_W'(v);
    endfunction

    // Divider preset of note n. Rests and unused indices give REST_PRESET.
    function automatic logic [PRESET_W-1:0] note_preset(input logic [NOTE_W-1:0] n);
        case (n)
            5'd1:  return 12'd1823;
            5'd2:  return 12'd2063;
            5'd3:  return 12'd2291;
            5'd4:  return 12'd2390;
            5'd5:  return 12'd2576;
            5'd6:  return 12'd2745;
            5'd7:  return 12'd2891;
            5'd8:  return 12'd2960;
            5'd9:  return 12'd3082;
            5'd10: return 12'd3193;
            5'd11: return 12'd3244;
            5'd12: return 12'd3337;
            5'd13: return 12'd3420;
            5'd14: return 12'd3494;
            5'd15: return 12'd3528;
            5'd16: return 12'd3589;
            5'd17: return 12'd3645;
            5'd18: return 12'd3670;
            5'd19: return 12'd3717;
            5'd20: return 12'd3758;
            5'd21: return 12'd3795;
            default: return REST_PRESET;
        endcase
    endfunction

endpackage

// File: rtl/mseq_tempo.sv
// Tempo divider: halves the tempo strobe to produce one advance pulse per
// quarter beat. Assumes tick is a single-cycle strobe. A clear restarts the
// phase so the next advance comes on the second tick after it.
module mseq_tempo (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic adv
);

    logic phase_q;

    // Advance on the second tick of each pair, unless a clear is pending.
    assign adv = tick & phase_q & ~clr;

    // Toggle the phase on each tick; reset or clear returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= 1'b0;
        else if (tick)     phase_q <= ~phase_q;
    end

    // A tick that did not advance is followed, at the next tick, by an advance.
    AST_SECOND_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !adv) |=> (!(tick && !clr) || adv)); // R1

endmodule

// File: rtl/mseq_addr.sv
// Score address counter: counts advance pulses modulo SONG_LEN. Assumes clr
// and adv never need to act together (clr wins).
module mseq_addr #(
    parameter int SONG_LEN = 183,
    localparam int ADDR_W  = $clog2(SONG_LEN),
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SONG_LEN - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    // Step the address, wrapping after the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  addr_q <= '0;
        else if (adv)       addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end

    assign addr = addr_q;

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= LAST); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && addr_q == LAST) |=> addr_q == '0); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && addr_q != LAST) |=> addr_q == $past(addr_q) + 1'b1); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(addr_q)); // R1
    AST_CLEAR_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> addr_q == '0); // R5

endmodule

// File: rtl/mseq_score.sv
// Score storage: one computed read-only table per song, selected by a binary
// song number. Assumes the song count is a power of two.
module mseq_score #(
    parameter int SEL_W    = 2,
    parameter int ADDR_W   = 8,
    localparam int NUM_SONGS = 2 ** SEL_W
) (
    input  logic [SEL_W-1:0]           song,
    input  logic [ADDR_W-1:0]          addr,
    output logic [mseq_pkg::NOTE_W-1:0] note
);

    logic [mseq_pkg::NOTE_W-1:0] lane_note [NUM_SONGS];

    // One table lane per song, each read at the shared address.
    for (genvar g = 0; g < NUM_SONGS; g++) begin : g_song
        assign lane_note[g] = mseq_pkg::song_note(g, int'(addr));
    end

    // Pick the lane of the song in use.
    assign note = lane_note[song];

endmodule

// File: rtl/mseq_decode.sv
// Note decoder: turns a note index into divider preset, scale-degree digit
// and one-hot octave. Assumes seven notes per octave; index 0 and indices
// above 21 decode as a rest.
module mseq_decode (
    input  logic [mseq_pkg::NOTE_W-1:0]   note,
    output logic [mseq_pkg::PRESET_W-1:0] preset,
    output logic [mseq_pkg::DEG_W-1:0]    degree,
    output logic [mseq_pkg::OCT_W-1:0]    octave
);

    // Split the index into octave and degree by range.
    always_comb begin
        preset = mseq_pkg::note_preset(note);
        degree = '0;
        octave = '0;
        if (note >= 5'd1 && note <= 5'd7) begin
            octave = 3'b001;
            degree = 4'(note);
        end else if (note >= 5'd8 && note <= 5'd14) begin
            octave = 3'b010;
            degree = 4'(note - 5'd7);
        end else if (note >= 5'd15 && note <= 5'd21) begin
            octave = 3'b100;
            degree = 4'(note - 5'd14);
        end
    end

endmodule

// File: rtl/melody_sequencer.sv
// Top: tempo divider, address counter, song tables and note decoder.
// Assumes tick_8hz is a synchronous one-cycle strobe and song_sel is already
// debounced and synchronous to clk.
module melody_sequencer #(
    parameter int SONG_LEN = 183,
    parameter int SEL_W    = 2,
    localparam int ADDR_W  = $clog2(SONG_LEN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick_8hz,
    input  logic [SEL_W-1:0]                song_sel,
    output logic [mseq_pkg::PRESET_W-1:0]   tone_preset,
    output logic [mseq_pkg::DEG_W-1:0]      degree_code,
    output logic [mseq_pkg::OCT_W-1:0]      octave_led
);

    logic [SEL_W-1:0]            sel_bin;
    logic [SEL_W-1:0]            song_q;
    logic                        chg;
    logic                        adv;
    logic [ADDR_W-1:0]           addr;
    logic [mseq_pkg::NOTE_W-1:0] note;

    // Gray to binary: each bit is the XOR of itself and all higher switch bits.
    always_comb begin
        for (int i = 0; i < SEL_W; i++) sel_bin[i] = ^(song_sel >> i);
    end

    // Track the song in use; a differing selection restarts playback.
    always_ff @(posedge clk) begin
        song_q <= sel_bin;
    end

    assign chg = rst_n && (sel_bin != song_q);

    mseq_tempo u_tempo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .tick  (tick_8hz),
        .adv   (adv)
    );

    mseq_addr #(.SONG_LEN(SONG_LEN)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chg),
        .adv   (adv),
        .addr  (addr)
    );

    mseq_score #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_score (
        .song  (song_q),
        .addr  (addr),
        .note  (note)
    );

    mseq_decode u_decode (
        .note   (note),
        .preset (tone_preset),
        .degree (degree_code),
        .octave (octave_led)
    );

    AST_OCT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(octave_led)); // R7
    AST_REST_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (degree_code == '0) == (octave_led == '0)); // R6
    AST_REST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (octave_led == '0) |-> (tone_preset == mseq_pkg::REST_PRESET)); // R8
    AST_DEGREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        degree_code <= 4'd7); // R6

endmodule

// File: tb/sim_melody_sequencer.sv
`timescale 1ns/1ps
// Bench: drives random and directed tick / switch patterns and compares all
// outputs on every cycle against a model built from the requirements.
module sim_melody_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [11:0] preset;
    logic [3:0]  degree;
    logic [2:0]  octave;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state.
    int m_addr  = 0;
    int m_phase = 0;
    int m_song  = 0;

    always #2.5 clk = ~clk;

    melody_sequencer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_8hz    (tick),
        .song_sel    (sel),
        .tone_preset (preset),
        .degree_code (degree),
        .octave_led  (octave)
    );

    // R4: switch code to song number.
    function automatic int gray_song(input logic [1:0] g);
        case (g)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // R2: stored note of song s at entry a.
    function automatic int exp_note(input int s, input int a);
        int lens[4]  = '{183, 150, 96, 40};
        int steps[4] = '{1, 3, 5, 2};
        int bases[4] = '{0, 7, 14, 3};
        if (a >= lens[s]) return 0;
        return ((a / 2) * steps[s] + bases[s]) % 21 + 1;
    endfunction

    // R8: preset of a note.
    function automatic int exp_preset(input int n);
        int tbl[22] = '{4095, 1823, 2063, 2291, 2390, 2576, 2745, 2891,
                        2960, 3082, 3193, 3244, 3337, 3420, 3494,
                        3528, 3589, 3645, 3670, 3717, 3758, 3795};
        return tbl[n];
    endfunction

    // R6: scale degree of a note.
    function automatic int exp_degree(input int n);
        return (n == 0) ? 0 : ((n - 1) % 7) + 1;
    endfunction

    // R7: octave indicator of a note.
    function automatic int exp_octave(input int n);
        if (n == 0) return 0;
        if (n <= 7) return 1;
        if (n <= 14) return 2;
        return 4;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (song %0d addr %0d)",
                     tag, act, exp, m_song, m_addr);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising
    // edge (R1, R3, R5, R9), compare at the next falling edge.
    task automatic cyc(input logic t, input logic [1:0] s, input logic r);
        int n;
        tick  = t;
        sel   = s;
        rst_n = r;
        @(posedge clk);
        if (!r) begin
            m_addr = 0; m_phase = 0; m_song = gray_song(s);
        end else if (gray_song(s) != m_song) begin
            m_song = gray_song(s); m_addr = 0; m_phase = 0;
        end else if (t) begin
            if (m_phase == 1) m_addr = (m_addr == 182) ? 0 : m_addr + 1;
            m_phase = 1 - m_phase;
        end
        @(negedge clk);
        if (r) begin
            n = exp_note(m_song, m_addr);
            check("R8/R2 preset", int'(preset), exp_preset(n));
            check("R6 degree", int'(degree), exp_degree(n));
            check("R7 octave", int'(octave), exp_octave(n));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        logic [1:0] cur_sel;
        seed_init = $urandom(32'd20240611);
        @(negedge clk);
        cyc(1'b0, 2'b00, 1'b0);
        cyc(1'b1, 2'b00, 1'b0);
        // R9: reset state shows entry 0 of song 0 (note 1).
        cyc(1'b0, 2'b00, 1'b1);
        check("R9 reset preset", int'(preset), 1823);
        check("R9 reset octave", int'(octave), 1);
        // R1: one tick alone does not advance; the second does.
        cyc(1'b1, 2'b00, 1'b1);
        cyc(1'b0, 2'b00, 1'b1);
        cyc(1'b1, 2'b00, 1'b1);
        // R3: run song 0 through its wrap with a tick every cycle.
        for (int i = 0; i < 380; i++) cyc(1'b1, 2'b00, 1'b1);
        // R4, R2: each other song, long enough to reach its rest padding.
        cyc(1'b0, 2'b01, 1'b1);
        for (int i = 0; i < 320; i++) cyc(1'b1, 2'b01, 1'b1);
        cyc(1'b0, 2'b11, 1'b1);
        for (int i = 0; i < 220; i++) cyc(1'b1, 2'b11, 1'b1);
        cyc(1'b0, 2'b10, 1'b1);
        for (int i = 0; i < 100; i++) cyc(1'b1, 2'b10, 1'b1);
        check("R2 padding rest", int'(preset), 4095);
        // R5: song change together with an advancing tick; change wins.
        cyc(1'b1, 2'b10, 1'b1);
        cyc(1'b1, 2'b00, 1'b1);
        check("R5 change clears", int'(preset), 1823);
        // R9: reset in the middle of playback.
        for (int i = 0; i < 30; i++) cyc(1'b1, 2'b00, 1'b1);
        cyc(1'b1, 2'b11, 1'b0);
        cyc(1'b0, 2'b11, 1'b1);
        check("R9 mid reset", int'(degree), exp_degree(exp_note(2, 0)));
        // Random ticks and occasional one-bit switch moves.
        cur_sel = 2'b11;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 150 == 0) cur_sel = cur_sel ^ (($urandom % 2) ? 2'b01 : 2'b10);
            cyc(($urandom % 4) != 0, cur_sel, ($urandom % 1000) != 0);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule